// File: doc/BRIEF.md
# Serial Command Bus Bridge

This block sits behind a byte-wide serial receiver and transmitter and lets a host drive a 32-bit memory-mapped bus. The host sends short binary frames: an opcode byte, a byte count, a four-byte address and, for writes, the data bytes. The bridge turns each frame into one or more word transactions on a simple request/acknowledge bus master port. For reads, it streams the requested bytes back on the outgoing byte stream.

Two registers are held inside the bridge in an eight-byte window at 0xF0000000. The word at 0xF0000000 is a general-purpose output register. The word at 0xF0000004 is a read-only identification word that the host reads to confirm the link is alive. Accesses to this window never reach the bus.

The incoming stream has a ready signal. The bridge lowers it while a bus transaction or a read response is in progress, so no byte is dropped. The outgoing stream uses a valid/ready handshake.

Top module: `sercmd_bridge`

## Requirements
- R1: Opcode 0x10 starts a write frame and opcode 0x11 starts a read frame. Any other byte received while waiting for an opcode is dropped, and the bridge keeps waiting for an opcode.
- R2: A frame continues with a count byte (0 to 255) and then four address bytes, most significant byte first.
- R3: Write data bytes are taken least significant byte first, so the first byte lands in bits 7:0. A word holding k bytes (k below 4) sets only byte enables 0 to k-1; bus_be bit i covers bits 8i+7:8i.
- R4: A read returns exactly the counted number of bytes, least significant byte first, and nothing else. A write returns no bytes.
- R5: When the count exceeds 4, the frame is split into word accesses, and the address rises by 4 after each word.
- R6: A read at 0xF0000004 returns the identification word ID_WORD (default 0xCAFE0001, upper half 0xCAFE) without a bus request. Writes to that address have no effect.
- R7: Address 0xF0000000 is a local output register shown on gpio_out. Writes to it honour the byte enables, and reads of it return its value, without a bus request.
- R8: All other addresses go to the bus port. bus_req stays high, with address, write data, write flag and byte enables unchanged, until the cycle in which bus_ack is high.
- R9: rx_ready is low while a bus access or a read response is pending, so every byte of a back-to-back command stream is consumed.
- R10: Once tx_valid is high, it stays high with tx_data unchanged until tx_ready is seen.
- R11: After reset, the bridge waits for an opcode with rx_ready high, tx_valid low and bus_req low, and gpio_out is zero.
- R12: A frame whose count is zero makes no bus access and returns no bytes, and the next frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Bridge accepts the incoming byte this cycle |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Downstream accepts the outgoing byte |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 32 | Word address of the transaction |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Byte enables |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transaction completes this cycle |
| gpio_out | output | 32 | Local output register |

## Verification
A parser that loses track of its position in a frame shows up at once in the next bus access: the address, byte enables or write data no longer match the frame, or an unexpected access appears on the bus. A fault in read sequencing shows up as a byte that is out of order, missing or extra on the outgoing stream, within the same frame. Errors in the local window show either as a stray bus request or as a wrong value on gpio_out or in the identification bytes. Randomised acknowledge latency and an intermittent tx_ready exercise the hold rules at every stall point.

// File: rtl/sercmd_pkg.sv
`timescale 1ns/1ps
package sercmd_pkg;

    localparam logic [7:0] OP_WR = 8'h10;
    localparam logic [7:0] OP_RD = 8'h11;
    localparam int LANES = 4;
    localparam int LW    = $clog2(LANES);

    typedef enum logic [2:0] {
        ST_OP, ST_CNT, ST_ADR, ST_WDAT, ST_BUS, ST_TX
    } st_e;

    typedef struct packed {
        st_e              st;
        logic             is_wr;
        logic [7:0]       left;
        logic [31:0]      addr;
        logic [31:0]      word;
        logic [LW-1:0]    lane;
        logic [LW:0]      nb;
    } ctx_t;

    function automatic logic [LANES-1:0] lanes_mask(input logic [LW:0] nb);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = ((LW+1)'(i) < nb);
        return m;
    endfunction

    function automatic logic [LW:0] clip_word(input logic [7:0] n);
        return (n >= 8'(LANES)) ? (LW+1)'(LANES) : n[LW:0];
    endfunction

endpackage

// File: rtl/sercmd_local.sv
`timescale 1ns/1ps
module sercmd_local #(
    parameter logic [31:0] ID_WORD = 32'hCAFE_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        sel_id,
    input  logic [31:0] wdata,
    input  logic [3:0]  be,
    output logic [31:0] rdata,
    output logic [31:0] gpio
);
    logic [31:0] gpio_d, gpio_q;

    always_comb begin
        gpio_d = gpio_q;
        for (int i = 0; i < 4; i++) begin
            if (wr_en && !sel_id && be[i]) gpio_d[i*8 +: 8] = wdata[i*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gpio_q <= '0;
        else        gpio_q <= gpio_d;
    end

    assign rdata = sel_id ? ID_WORD : gpio_q;
    assign gpio  = gpio_q;

    // R7
    full_word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_id && be == 4'hF) |=> gpio_q == $past(wdata));
    // R6
    id_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_id) |=> $stable(gpio_q));
endmodule

// File: rtl/sercmd_fsm.sv
`timescale 1ns/1ps
module sercmd_fsm
    import sercmd_pkg::*;
#(
    parameter logic [31:0] LOCAL_BASE = 32'hF000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    output logic [3:0]  bus_be,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack,
    output logic        loc_wr,
    input  logic [31:0] loc_rdata
);
    ctx_t d, q;
    logic hit, done;
    logic [31:0] rd_word;

    assign hit = (q.addr[31:3] == LOCAL_BASE[31:3]);

    always_comb begin
        d        = q;
        rx_ready = 1'b0;
        tx_valid = 1'b0;
        bus_req  = 1'b0;
        loc_wr   = 1'b0;
        done     = 1'b0;
        rd_word  = '0;
        case (q.st)
            ST_OP: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    if (rx_data == OP_WR) begin
                        d.is_wr = 1'b1;
                        d.st    = ST_CNT;
                    end else if (rx_data == OP_RD) begin
                        d.is_wr = 1'b0;
                        d.st    = ST_CNT;
                    end
                end
            end
            ST_CNT: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.left = rx_data;
                    d.lane = '0;
                    d.st   = ST_ADR;
                end
            end
            ST_ADR: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.addr = {q.addr[23:0], rx_data};
                    d.lane = q.lane + 1'b1;
                    if (q.lane == LW'(LANES-1)) begin
                        d.lane = '0;
                        d.word = '0;
                        if (q.left == 8'd0)  d.st = ST_OP;
                        else if (q.is_wr)    d.st = ST_WDAT;
                        else begin
                            d.nb = clip_word(q.left);
                            d.st = ST_BUS;
                        end
                    end
                end
            end
            ST_WDAT: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.word[{q.lane, 3'b000} +: 8] = rx_data;
                    d.lane = q.lane + 1'b1;
                    d.left = q.left - 8'd1;
                    if (q.lane == LW'(LANES-1) || q.left == 8'd1) begin
                        d.nb = {1'b0, q.lane} + 1'b1;
                        d.st = ST_BUS;
                    end
                end
            end
            ST_BUS: begin
                if (hit) begin
                    done    = 1'b1;
                    loc_wr  = q.is_wr;
                    rd_word = loc_rdata;
                end else begin
                    bus_req = 1'b1;
                    done    = bus_ack;
                    rd_word = bus_rdata;
                end
                if (done) begin
                    d.addr = q.addr + 32'd4;
                    d.lane = '0;
                    if (q.is_wr) begin
                        d.word = '0;
                        d.st   = (q.left == 8'd0) ? ST_OP : ST_WDAT;
                    end else begin
                        d.word = rd_word;
                        d.st   = ST_TX;
                    end
                end
            end
            ST_TX: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    d.lane = q.lane + 1'b1;
                    d.left = q.left - 8'd1;
                    if (q.left == 8'd1) d.st = ST_OP;
                    else if (q.lane == LW'(LANES-1)) begin
                        d.lane = '0;
                        d.nb   = clip_word(q.left - 8'd1);
                        d.st   = ST_BUS;
                    end
                end
            end
            default: d.st = ST_OP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_OP;
        end else begin
            q <= d;
        end
    end

    assign tx_data   = q.word[{q.lane, 3'b000} +: 8];
    assign bus_addr  = q.addr;
    assign bus_wdata = q.word;
    assign bus_we    = q.is_wr;
    assign bus_be    = lanes_mask(q.nb);

    // R1
    bad_opcode_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_OP && rx_valid && rx_data != OP_WR && rx_data != OP_RD) |=> q.st == ST_OP);
    // R12
    zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADR && rx_valid && q.lane == LW'(LANES-1) && q.left == 8'd0) |=> q.st == ST_OP);
    // R8
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)
                                   && $stable(bus_be) && $stable(bus_we)));
    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> bus_addr == $past(bus_addr) + 32'd4);
endmodule

// File: rtl/sercmd_bridge.sv
`timescale 1ns/1ps
module sercmd_bridge #(
    parameter logic [31:0] LOCAL_BASE = 32'hF000_0000,
    parameter logic [31:0] ID_WORD    = 32'hCAFE_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    output logic [3:0]  bus_be,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack,
    output logic [31:0] gpio_out
);
    logic        loc_wr;
    logic [31:0] loc_rdata;

    sercmd_fsm #(.LOCAL_BASE(LOCAL_BASE)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .loc_wr(loc_wr), .loc_rdata(loc_rdata)
    );

    sercmd_local #(.ID_WORD(ID_WORD)) u_local (
        .clk(clk), .rst_n(rst_n), .wr_en(loc_wr), .sel_id(bus_addr[2]),
        .wdata(bus_wdata), .be(bus_be), .rdata(loc_rdata), .gpio(gpio_out)
    );
endmodule

// File: tb/sercmd_bridge_test.sv
`timescale 1ns/1ps
module sercmd_bridge_test;
    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
    } busop_t;

    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, tx_ready = 0, bus_ack = 0;
    logic [7:0] rx_data = 0;
    logic [31:0] bus_rdata = 0;
    logic rx_ready, tx_valid, bus_req, bus_we;
    logic [7:0] tx_data;
    logic [31:0] bus_addr, bus_wdata, gpio_out;
    logic [3:0] bus_be;

    int checks = 0, failures = 0;
    logic [7:0] exp_tx[$];
    busop_t exp_bus[$];
    logic [31:0] mem [16];
    bit done_flag = 0;

    always #5 clk = ~clk;

    sercmd_bridge uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .gpio_out(gpio_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        #1;
        while (!rx_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic frame(input logic [7:0] op, input logic [7:0] n, input logic [31:0] a);
        send(op); send(n);
        send(a[31:24]); send(a[23:16]); send(a[15:8]); send(a[7:0]);
    endtask

    task automatic idle_settle();
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic push_bus(input logic we, input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be);
        busop_t e;
        e.we = we; e.addr = a; e.wdata = wd; e.be = be;
        exp_bus.push_back(e);
    endtask

    task automatic push_word_bytes(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) exp_tx.push_back(w[i*8 +: 8]);
    endtask

    // bus slave and bus monitor
    initial begin
        int wait_cnt = 0;
        int lat = 0;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0103_0507);
        forever begin
            @(negedge clk);
            if (bus_req) begin
                bus_ack = (wait_cnt >= lat);
                wait_cnt++;
            end else begin
                bus_ack  = 1'b0;
                wait_cnt = 0;
            end
            bus_rdata = mem[bus_addr[5:2]];
            #1;
            if (bus_req && bus_ack) begin
                logic [31:0] m;
                for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{bus_be[i]}};
                // R9: input stalled during bus access
                check(!rx_ready, "R9 rx_ready during bus access", {31'd0, rx_ready}, 32'd0);
                if (exp_bus.size() == 0) begin
                    check(0, "R8 unexpected bus access", bus_addr, 32'hFFFF_FFFF);
                end else begin
                    busop_t e;
                    e = exp_bus.pop_front();
                    check(bus_addr == e.addr, "R2/R5 bus address", bus_addr, e.addr);
                    check(bus_we == e.we, "R1 bus direction", {31'd0, bus_we}, {31'd0, e.we});
                    check(bus_be == e.be, "R3 byte enables", {28'd0, bus_be}, {28'd0, e.be});
                    if (e.we)
                        check((bus_wdata & m) == (e.wdata & m), "R3 write data", bus_wdata & m, e.wdata & m);
                end
                if (bus_we)
                    mem[bus_addr[5:2]] = (mem[bus_addr[5:2]] & ~m) | (bus_wdata & m);
                wait_cnt = 0;
                lat = (lat + 1) % 4;
            end
        end
    end

    // outgoing stream monitor with intermittent ready
    initial begin
        int cyc = 0;
        bit hold = 0;
        logic [7:0] held = 0;
        forever begin
            @(negedge clk);
            tx_ready = (cyc % 3) != 1;
            cyc++;
            #1;
            if (hold) begin
                // R10
                check(tx_valid && tx_data == held, "R10 tx hold", {23'd0, tx_valid, tx_data}, {23'd1, held});
            end
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) check(0, "R4 extra output byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    check(tx_data == e, "R4 output byte", {24'd0, tx_data}, {24'd0, e});
                end
            end
            hold = tx_valid && !tx_ready;
            held = tx_data;
        end
    end

    initial begin
        #2_000_000;
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R11 reset state
        check(rx_ready == 1'b1, "R11 rx_ready after reset", {31'd0, rx_ready}, 32'd1);
        check(tx_valid == 1'b0, "R11 tx_valid after reset", {31'd0, tx_valid}, 32'd0);
        check(bus_req == 1'b0, "R11 bus_req after reset", {31'd0, bus_req}, 32'd0);
        check(gpio_out == 32'd0, "R11 gpio after reset", gpio_out, 32'd0);

        // R6 identification probe, answered locally
        push_word_bytes(32'hCAFE_0001, 4);
        frame(8'h11, 8'd4, 32'hF000_0004);
        idle_settle();

        // R1 junk bytes dropped, then a normal read
        send(8'h55); send(8'hFF);
        push_bus(0, 32'h0000_0008, 0, 4'hF);
        push_word_bytes(mem[2], 4);
        frame(8'h11, 8'd4, 32'h0000_0008);
        idle_settle();

        // R3 R4 single-word write, no response bytes
        push_bus(1, 32'h0000_0010, 32'h1122_3344, 4'hF);
        frame(8'h10, 8'd4, 32'h0000_0010);
        send(8'h44); send(8'h33); send(8'h22); send(8'h11);
        idle_settle();

        // R3 partial read of three bytes
        push_bus(0, 32'h0000_0010, 0, 4'h7);
        push_word_bytes(32'h1122_3344, 3);
        frame(8'h11, 8'd3, 32'h0000_0010);
        idle_settle();

        // R5 six-byte write spans two words
        push_bus(1, 32'h0000_0020, 32'h0403_0201, 4'hF);
        push_bus(1, 32'h0000_0024, 32'h0000_0605, 4'h3);
        frame(8'h10, 8'd6, 32'h0000_0020);
        for (int i = 1; i <= 6; i++) send(8'(i));
        idle_settle();

        // R5 six-byte read back
        push_bus(0, 32'h0000_0020, 0, 4'hF);
        push_bus(0, 32'h0000_0024, 0, 4'h3);
        for (int i = 1; i <= 6; i++) exp_tx.push_back(8'(i));
        frame(8'h11, 8'd6, 32'h0000_0020);
        idle_settle();

        // R7 local output register
        frame(8'h10, 8'd4, 32'hF000_0000);
        send(8'h78); send(8'h56); send(8'h34); send(8'h12);
        idle_settle();
        check(gpio_out == 32'h1234_5678, "R7 gpio full write", gpio_out, 32'h1234_5678);
        frame(8'h10, 8'd1, 32'hF000_0000);
        send(8'hAA);
        idle_settle();
        check(gpio_out == 32'h1234_56AA, "R7 gpio byte write", gpio_out, 32'h1234_56AA);
        push_word_bytes(32'h1234_56AA, 4);
        frame(8'h11, 8'd4, 32'hF000_0000);
        idle_settle();

        // R6 write to identification word ignored
        frame(8'h10, 8'd4, 32'hF000_0004);
        send(8'h00); send(8'h00); send(8'h00); send(8'h00);
        idle_settle();
        check(gpio_out == 32'h1234_56AA, "R6 gpio untouched by id write", gpio_out, 32'h1234_56AA);
        push_word_bytes(32'hCAFE_0001, 4);
        frame(8'h11, 8'd4, 32'hF000_0004);
        idle_settle();

        // R12 zero count, then a one-byte read
        frame(8'h11, 8'd0, 32'h0000_0008);
        push_bus(0, 32'h0000_0008, 0, 4'h1);
        exp_tx.push_back(mem[2][7:0]);
        frame(8'h11, 8'd1, 32'h0000_0008);
        idle_settle();

        // R4 nothing left outstanding or missing
        check(exp_tx.size() == 0, "R4 missing output bytes", exp_tx.size(), 0);
        check(exp_bus.size() == 0, "R8 missing bus accesses", exp_bus.size(), 0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule